// File: doc/BRIEF.md
# Parallel EEPROM Page-Write Sequencer

This block models the internal write engine of a byte-wide parallel EEPROM. The bus side has active-low strobes for chip select, write enable and output enable, a 15-bit address, an 8-bit data input and a registered data output with a drive-enable flag. All three strobes are treated as asynchronous. Each passes through a two-flop synchroniser, and one more register stage serves edge detection.

A write happens while chip select and write enable are both low and output enable is high. The address is taken when this overlap starts, which is when the later of the two strobes falls. The data is taken when the overlap ends, which is when the earlier strobe rises. Accepted bytes go into a 64-entry page buffer. The first accepted byte fixes the page, and the byte's offset inside the page comes from the low address bits. A retriggerable collection window stays open while write-enable falling edges keep arriving. Once the window times out, a self-timed programming phase copies the buffered bytes into a small backing array.

While programming runs, reads return a polling status instead of stored data. Writes attempted during programming are dropped. All durations are parameters counted in clock cycles.

The controller state machine has three states. `ST_IDLE` waits for a first byte. `ST_COLLECT` keeps the page window open. `ST_PROGRAM` performs the timed commit. The transitions are:
- `T_FIRST` goes from `ST_IDLE` to `ST_COLLECT` when a byte is accepted.
- `T_EXPIRE` goes from `ST_COLLECT` to `ST_PROGRAM` when the window counter reaches its limit with no fresh write-enable fall.
- `T_DONE` goes from `ST_PROGRAM` to `ST_IDLE` when the programming counter reaches its limit.

Top module: `eeprom_page_writer`

## Requirements
- R1: After reset, `dout_en` and `dout` are 0 and every stored byte reads as 0x00.
- R2: Three clock edges after the raw strobes settle, `dout_en` is 1 exactly when `cs_n`=0, `oe_n`=0 and `we_n`=1. Outside the programming phase, `dout` then holds the stored byte for `addr`. Whenever `dout_en` is 0, `dout` is 0x00.
- R3: A byte is accepted only while `cs_n`=0, `we_n`=0 and `oe_n`=1 hold together. A strobe overlap that happens with `oe_n`=0 stores nothing.
- R4: The address is sampled when the write overlap begins, which is the later falling strobe. The data is sampled when the overlap ends, which is the earlier rising strobe. Address changes after the start of the overlap, and data values present before its end, have no effect.
- R5: Each accepted byte lands at buffer offset `addr[5:0]`. The page number `addr[14:6]` of the first byte in a window applies to the whole window, so page bits of later bytes are ignored. If the same offset is written twice, the last byte wins.
- R6: The window counter restarts on every synchronised falling edge of `we_n`, including edges with `cs_n` high. Programming starts only after `PAGE_CYC` consecutive cycles in `ST_COLLECT` without such an edge.
- R7: `ST_PROGRAM` lasts `PROG_CYC` cycles. At its end the buffered bytes are written into the array and the state returns to `ST_IDLE`.
- R8: A read during programming returns bit 7 equal to the complement of bit 7 of the last accepted byte, with bits 6..0 equal to 0.
- R9: Writes attempted during programming store nothing and leave the polling value unchanged.
- R10: The array holds `STORE_PAGES` pages. A page number maps to entry `page % STORE_PAGES`. Offsets not written in a window keep their old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select strobe, active low, asynchronous |
| we_n | input | 1 | Write enable strobe, active low, asynchronous |
| oe_n | input | 1 | Output enable strobe, active low, asynchronous |
| addr | input | 15 | Byte address; bits [5:0] are the page offset |
| din | input | 8 | Write data |
| dout | output | 8 | Registered read data or polling status |
| dout_en | output | 1 | High while the output would be driven |

## Verification
The bench runs the write path under several strobe orders:
- Write-enable-controlled writes exercise the basic path.
- Chip-select-controlled writes move the address and data during the overlap, which separates capture at the overlap start from capture at the overlap end.
- Strobes with output enable low show that a write is ignored when the enable condition fails.

For the window, a train of write-enable pulses with chip select high separates a retriggerable window from a one-shot one. A read taken immediately afterwards must still return stored data rather than polling status.

Further patterns cover the remaining rules:
- Reads during programming, and writes injected into it, distinguish the polling value from stored data and confirm the dropped write.
- Writes that mix page bits and repeat an offset show which page is used and that the last byte wins.
- An aliased page number confirms the modulo mapping into the array.

// File: rtl/eepw_pkg.sv
package eepw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_PROGRAM = 2'd2
    } wstate_t;

    // strobe bit positions in the synchronised vector
    localparam int SB_CS = 2;
    localparam int SB_WE = 1;
    localparam int SB_OE = 0;
endpackage

// File: rtl/eepw_sync.sv
module eepw_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] lvl,
    output logic [W-1:0] prv
);
    logic [W-1:0] meta;

    // strobes idle high, so reset to all ones to avoid false edges
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '1;
            lvl  <= '1;
            prv  <= '1;
        end else begin
            meta <= raw;
            lvl  <= meta;
            prv  <= lvl;
        end
    end
endmodule

// File: rtl/eepw_store.sv
module eepw_store #(
    parameter int ADDR_W      = 15,
    parameter int DATA_W      = 8,
    parameter int OFF_W       = 6,
    parameter int STORE_PAGES = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             rd_addr,
    output logic [DATA_W-1:0]             rd_data,
    input  logic                          wr_en,
    input  logic [ADDR_W-OFF_W-1:0]       wr_page,
    input  logic [(1<<OFF_W)*DATA_W-1:0]  wr_bytes,
    input  logic [(1<<OFF_W)-1:0]         wr_mask
);
    localparam int PAGE_SZ = 1 << OFF_W;
    localparam int SP_W    = $clog2(STORE_PAGES);
    localparam int IDX_W   = SP_W + OFF_W;
    localparam int DEPTH   = STORE_PAGES * PAGE_SZ;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [SP_W-1:0]   rd_pi;
    logic [SP_W-1:0]   wr_pi;
    logic [IDX_W-1:0]  rd_idx;

    always_comb begin
        rd_pi   = SP_W'(rd_addr[ADDR_W-1:OFF_W] % STORE_PAGES);
        wr_pi   = SP_W'(wr_page % STORE_PAGES);
        rd_idx  = {rd_pi, rd_addr[OFF_W-1:0]};
        rd_data = mem[rd_idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            for (int j = 0; j < PAGE_SZ; j++) begin
                if (wr_mask[j])
                    mem[{wr_pi, OFF_W'(j)}] <= wr_bytes[j*DATA_W +: DATA_W];
            end
        end
    end
endmodule

// File: rtl/eepw_ctrl.sv
module eepw_ctrl
    import eepw_pkg::*;
#(
    parameter int ADDR_W   = 15,
    parameter int DATA_W   = 8,
    parameter int OFF_W    = 6,
    parameter int PAGE_CYC = 30000,
    parameter int PROG_CYC = 2000000
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [2:0]                          lvl,
    input  logic [2:0]                          prv,
    input  logic [ADDR_W-1:0]                   addr,
    input  logic [DATA_W-1:0]                   din,
    output wstate_t                             state,
    output logic                                busy,
    output logic [DATA_W-1:0]                   last_byte,
    output logic [$clog2(PROG_CYC+1)-1:0]       prog_cnt,
    output logic                                prog_we,
    output logic [ADDR_W-OFF_W-1:0]             prog_page,
    output logic [(1<<OFF_W)*DATA_W-1:0]        buf_bytes,
    output logic [(1<<OFF_W)-1:0]               buf_mask
);
    localparam int PAGE_SZ = 1 << OFF_W;
    localparam int PG_W    = ADDR_W - OFF_W;
    localparam int WC_W    = $clog2(PAGE_CYC + 1);
    localparam int PC_W    = $clog2(PROG_CYC + 1);

    wstate_t           nxt;
    logic              wr_now, wr_was, wr_rise, wr_fall, we_fall;
    logic              armed, commit, win_done, prog_done;
    logic [OFF_W-1:0]  lat_off;
    logic [PG_W-1:0]   lat_pg;
    logic [PG_W-1:0]   page;
    logic [WC_W-1:0]   win_cnt;
    logic [DATA_W-1:0] pbuf [PAGE_SZ];

    always_comb begin
        wr_now    = ~lvl[SB_CS] & ~lvl[SB_WE] & lvl[SB_OE];
        wr_was    = ~prv[SB_CS] & ~prv[SB_WE] & prv[SB_OE];
        wr_rise   = wr_now & ~wr_was;
        wr_fall   = ~wr_now & wr_was;
        we_fall   = prv[SB_WE] & ~lvl[SB_WE];
        commit    = wr_fall & armed & (state != ST_PROGRAM);
        win_done  = (win_cnt == WC_W'(PAGE_CYC - 1));
        prog_done = (prog_cnt == PC_W'(PROG_CYC - 1));
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (commit)               nxt = ST_COLLECT;  // T_FIRST
            ST_COLLECT: if (!we_fall && win_done) nxt = ST_PROGRAM;  // T_EXPIRE
            ST_PROGRAM: if (prog_done)            nxt = ST_IDLE;     // T_DONE
            default:                              nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // state-driven outputs
    always_comb begin
        busy      = (state == ST_PROGRAM);
        prog_we   = (state == ST_PROGRAM) && prog_done;
        prog_page = page;
    end

    // capture, counters and buffer bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed     <= 1'b0;
            lat_off   <= '0;
            lat_pg    <= '0;
            page      <= '0;
            win_cnt   <= '0;
            prog_cnt  <= '0;
            last_byte <= '0;
            buf_mask  <= '0;
        end else begin
            if (state == ST_PROGRAM) begin
                armed <= 1'b0;
            end else if (wr_rise) begin
                armed   <= 1'b1;
                lat_off <= addr[OFF_W-1:0];
                lat_pg  <= addr[ADDR_W-1:OFF_W];
            end else if (wr_fall) begin
                armed <= 1'b0;
            end

            if (commit) begin
                last_byte <= din;
                if (state == ST_IDLE) page <= lat_pg;
            end

            if (state == ST_COLLECT) begin
                if (we_fall)       win_cnt <= '0;
                else if (!win_done) win_cnt <= win_cnt + 1'b1;
            end else begin
                win_cnt <= '0;
            end

            if (state != ST_PROGRAM) prog_cnt <= '0;
            else if (!prog_done)     prog_cnt <= prog_cnt + 1'b1;

            if (prog_we)     buf_mask          <= '0;
            else if (commit) buf_mask[lat_off] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (commit) pbuf[lat_off] <= din;
    end

    for (genvar g = 0; g < PAGE_SZ; g++) begin : g_flat
        assign buf_bytes[g*DATA_W +: DATA_W] = pbuf[g];
    end
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
    import eepw_pkg::*;
#(
    parameter int ADDR_W      = 15,
    parameter int DATA_W      = 8,
    parameter int OFF_W       = 6,
    parameter int STORE_PAGES = 4,
    parameter int PAGE_CYC    = 30000,
    parameter int PROG_CYC    = 2000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);
    localparam int PAGE_SZ = 1 << OFF_W;
    localparam int PG_W    = ADDR_W - OFF_W;
    localparam int PC_W    = $clog2(PROG_CYC + 1);

    logic [2:0]                s_lvl, s_prv;
    wstate_t                   st;
    logic                      busy;
    logic [DATA_W-1:0]         last_b;
    logic [PC_W-1:0]           pcnt;
    logic                      prog_we;
    logic [PG_W-1:0]           prog_page;
    logic [PAGE_SZ*DATA_W-1:0] bytes_flat;
    logic [PAGE_SZ-1:0]        bmask;
    logic [DATA_W-1:0]         rdata;
    logic [DATA_W-1:0]         poll_val;
    logic                      rd_lvl;

    eepw_sync #(.W(3)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   ({cs_n, we_n, oe_n}),
        .lvl   (s_lvl),
        .prv   (s_prv)
    );

    eepw_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W),
        .PAGE_CYC(PAGE_CYC), .PROG_CYC(PROG_CYC)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .lvl       (s_lvl),
        .prv       (s_prv),
        .addr      (addr),
        .din       (din),
        .state     (st),
        .busy      (busy),
        .last_byte (last_b),
        .prog_cnt  (pcnt),
        .prog_we   (prog_we),
        .prog_page (prog_page),
        .buf_bytes (bytes_flat),
        .buf_mask  (bmask)
    );

    eepw_store #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W), .STORE_PAGES(STORE_PAGES)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_addr  (addr),
        .rd_data  (rdata),
        .wr_en    (prog_we),
        .wr_page  (prog_page),
        .wr_bytes (bytes_flat),
        .wr_mask  (bmask)
    );

    always_comb begin
        rd_lvl   = ~s_lvl[SB_CS] & ~s_lvl[SB_OE] & s_lvl[SB_WE];
        poll_val = '0;
        poll_val[DATA_W-1] = ~last_b[DATA_W-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_en <= 1'b0;
            dout    <= '0;
        end else begin
            dout_en <= rd_lvl;
            dout    <= rd_lvl ? (busy ? poll_val : rdata) : '0;
        end
    end
endmodule

// File: rtl/eepw_checker.sv
module eepw_checker
    import eepw_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int PAGE_SZ  = 64,
    parameter int PROG_CYC = 2000000
) (
    input logic                          clk,
    input logic                          rst_n,
    input wstate_t                       st,
    input logic [$clog2(PROG_CYC+1)-1:0] pcnt,
    input logic [PAGE_SZ-1:0]            bmask,
    input logic [DATA_W-1:0]             last_b,
    input logic [DATA_W-1:0]             dout,
    input logic                          dout_en
);
    localparam int PC_W = $clog2(PROG_CYC + 1);

    p_quiet_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_en |-> dout == '0);

    p_no_skip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_IDLE |=> st != ST_PROGRAM);

    p_prog_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PROGRAM && pcnt != PC_W'(PROG_CYC - 1)) |=> st == ST_PROGRAM);

    p_prog_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PROGRAM && pcnt == PC_W'(PROG_CYC - 1)) |=> st == ST_IDLE);

    p_poll_val_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_en && $past(st) == ST_PROGRAM) |->
            (dout[DATA_W-1] == ~$past(last_b[DATA_W-1]) && dout[DATA_W-2:0] == '0));

    p_empty_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_IDLE |-> bmask == '0);

    p_last_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PROGRAM && $past(st) == ST_PROGRAM) |-> $stable(last_b));
endmodule

bind eeprom_page_writer eepw_checker #(
    .DATA_W(DATA_W), .PAGE_SZ(1 << OFF_W), .PROG_CYC(PROG_CYC)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .st      (st),
    .pcnt    (pcnt),
    .bmask   (bmask),
    .last_b  (last_b),
    .dout    (dout),
    .dout_en (dout_en)
);

// File: tb/test_eeprom_page_writer.sv
`timescale 1ns/100ps
module test_eeprom_page_writer;
    localparam int PAGE_CYC = 40;
    localparam int PROG_CYC = 120;
    localparam int SP       = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [14:0] addr = '0;
    logic [7:0]  din = '0;
    logic [7:0]  dout;
    logic        dout_en;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    string cur_req = "R1";

    eeprom_page_writer #(
        .STORE_PAGES(SP), .PAGE_CYC(PAGE_CYC), .PROG_CYC(PROG_CYC)
    ) i_eeprom_page_writer (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
    );

    always #2.5 clk = ~clk;

    // behavioural reference model
    logic [2:0]  m1 = 3'b111, m2 = 3'b111, mp = 3'b111;
    int          mstate = 0;
    int          wcnt = 0, pcnt = 0;
    bit          arm = 0;
    logic [14:0] maddr = '0;
    logic [8:0]  mpage = '0;
    logic [7:0]  mlast = '0;
    logic [7:0]  mmem [SP*64];
    logic [7:0]  pbuf [int];
    logic [7:0]  exp_do = '0;
    bit          exp_en = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m1 = 3'b111; m2 = 3'b111; mp = 3'b111;
            mstate = 0; wcnt = 0; pcnt = 0; arm = 0; mlast = '0;
            foreach (mmem[i]) mmem[i] = '0;
            pbuf.delete();
            exp_do = '0; exp_en = 0;
        end else begin
            bit wr, wrp, wefall, rd, commit;
            logic [14:0] ca;
            logic [7:0] nd;
            wr     = !m2[2] && !m2[1] && m2[0];
            wrp    = !mp[2] && !mp[1] && mp[0];
            wefall = mp[1] && !m2[1];
            rd     = !m2[2] && !m2[0] && m2[1];
            if (!rd) nd = 8'h00;
            else if (mstate == 2) nd = {~mlast[7], 7'b0};
            else nd = mmem[(int'(addr[14:6]) % SP) * 64 + int'(addr[5:0])];
            commit = !wr && wrp && arm && (mstate != 2);
            ca = maddr;
            if (mstate == 2) arm = 0;
            else if (wr && !wrp) begin arm = 1; maddr = addr; end
            else if (!wr && wrp) arm = 0;
            case (mstate)
                0: if (commit) begin
                    mpage = ca[14:6]; pbuf[int'(ca[5:0])] = din; mlast = din;
                    wcnt = 0; mstate = 1;
                end
                1: begin
                    if (commit) begin pbuf[int'(ca[5:0])] = din; mlast = din; end
                    if (wefall) wcnt = 0;
                    else if (wcnt == PAGE_CYC - 1) begin mstate = 2; pcnt = 0; end
                    else wcnt++;
                end
                default: begin
                    if (pcnt == PROG_CYC - 1) begin
                        foreach (pbuf[k]) mmem[(int'(mpage) % SP) * 64 + k] = pbuf[k];
                        pbuf.delete();
                        mstate = 0;
                    end else pcnt++;
                end
            endcase
            exp_en = rd; exp_do = nd;
            mp = m2; m2 = m1; m1 = {cs_n, we_n, oe_n};
        end
    end

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (dout_en !== exp_en || dout !== exp_do) begin
                errors++;
                $display("FAIL %s cycle %0d: dout_en=%0b dout=%02h expected dout_en=%0b dout=%02h",
                         cur_req, cyc, dout_en, dout, exp_en, exp_do);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            errors++;
            $display("FAIL watchdog: run hung, got cycle %0d expected completion", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic wr_we(logic [14:0] a, logic [7:0] d, logic oe_v);
        @(negedge clk);
        addr = a; din = d; oe_n = oe_v; cs_n = 1'b0;
        repeat (3) @(negedge clk);
        we_n = 1'b0;
        repeat (4) @(negedge clk);
        we_n = 1'b1;
        repeat (4) @(negedge clk);
        cs_n = 1'b1; oe_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    // chip-select-controlled write; address and data move mid-overlap
    task automatic wr_cs(logic [14:0] a, logic [14:0] a_late, logic [7:0] d_early, logic [7:0] d);
        @(negedge clk);
        we_n = 1'b0; addr = a; din = d_early; oe_n = 1'b1;
        repeat (3) @(negedge clk);
        cs_n = 1'b0;
        repeat (3) @(negedge clk);
        addr = a_late; din = d;
        repeat (3) @(negedge clk);
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
        we_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic rd(logic [14:0] a, logic [7:0] exp, string tag);
        @(negedge clk);
        addr = a; cs_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(tag, {7'b0, dout_en}, 8'h01);
        chk(tag, dout, exp);
        cs_n = 1'b1; oe_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic wait_state(int s);
        while (mstate != s) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk("R1 reset dout_en", {7'b0, dout_en}, 8'h00);
        chk("R1 reset dout", dout, 8'h00);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        cur_req = "R1";
        rd(15'h0005, 8'h00, "R1 erased byte");

        // basic page write, polling and commit
        cur_req = "R7";
        wr_we(15'h0040, 8'h11, 1'b1);
        wr_we(15'h0041, 8'h22, 1'b1);
        wr_we(15'h0042, 8'h25, 1'b1);
        wait_state(2);
        cur_req = "R8";
        rd(15'h0040, 8'h80, "R8 polling complement of bit7");
        wait_state(0);
        cur_req = "R2";
        rd(15'h0040, 8'h11, "R7 stored byte 0");
        rd(15'h0041, 8'h22, "R7 stored byte 1");
        rd(15'h0042, 8'h25, "R2 read stored byte 2");

        // chip-select-controlled write, late address/data changes
        cur_req = "R4";
        wr_cs(15'h0010, 15'h0013, 8'h44, 8'hC3);
        wait_state(2); wait_state(0);
        rd(15'h0010, 8'hC3, "R4 addr at overlap start, data at end");
        rd(15'h0013, 8'h00, "R4 late address unused");

        // write with output enable low is inhibited
        cur_req = "R3";
        wr_we(15'h0005, 8'h5A, 1'b0);
        repeat (PAGE_CYC + 20) @(negedge clk);
        chk("R3 no collect after inhibited write", 8'(mstate), 8'd0);
        rd(15'h0005, 8'h00, "R3 inhibited write not stored");

        // retriggered window
        cur_req = "R6";
        wr_we(15'h00C1, 8'h12, 1'b1);
        for (int i = 0; i < 6; i++) begin
            repeat (25) @(negedge clk);
            we_n = 1'b0;
            repeat (2) @(negedge clk);
            we_n = 1'b1;
        end
        rd(15'h00C1, 8'h00, "R6 window still open after retriggers");
        wait_state(2); wait_state(0);
        rd(15'h00C1, 8'h12, "R6 byte programmed after window");

        // page fixed by first byte, last write wins
        cur_req = "R5";
        wr_we(15'h00A0, 8'h31, 1'b1);
        wr_we(15'h01E1, 8'h32, 1'b1);
        wr_we(15'h00A0, 8'h33, 1'b1);
        wait_state(2); wait_state(0);
        rd(15'h00A0, 8'h33, "R5 repeated offset last wins");
        rd(15'h00A1, 8'h32, "R5 later page bits ignored");
        rd(15'h01E1, 8'h00, "R5 foreign page untouched");

        // writes during programming are dropped
        cur_req = "R9";
        wr_we(15'h0020, 8'h55, 1'b1);
        wait_state(2);
        wr_we(15'h0021, 8'hFF, 1'b1);
        rd(15'h0020, 8'h80, "R9 poll unchanged by dropped write");
        wait_state(0);
        rd(15'h0021, 8'h00, "R9 dropped write not stored");
        rd(15'h0020, 8'h55, "R9 earlier byte stored");

        // page aliasing, untouched offsets kept
        cur_req = "R10";
        wr_we(15'h0141, 8'h77, 1'b1);
        wait_state(2); wait_state(0);
        rd(15'h0041, 8'h77, "R10 page 5 aliases to entry 1");
        rd(15'h0040, 8'h11, "R10 unwritten offset keeps old byte");
        rd(15'h0042, 8'h25, "R10 unwritten offset keeps old byte");

        repeat (5) @(negedge clk);
        summary();
        $finish;
    end
endmodule